// File: doc/BRIEF.md
# Raised-Cosine Windowed Bitstream Accumulator

This block turns the one-bit output of a sigma-delta modulator comparator into a multi-bit conversion result, one result per measurement. It takes one comparator bit on every clock edge of a measurement. It multiplies each bit by a window weight and adds the product into an accumulator. At the end it rounds the sum, divides it by 32, and presents the result together with a one-clock done pulse.

The weight rises along a raised-cosine shape over the first 32 samples. It holds at full scale (64) through the body of the measurement. It falls along the mirrored shape over the last 32 samples. Tapering the edges this way suppresses the error caused by partial modulator patterns at the start and end of a measurement.

The ramp is not stored as a table of weights. A 5-bit position counter selects a 2-bit increment. The increment is added to a 7-bit window register on the way up, and subtracted in reverse position order on the way down. One control input turns the window off, which gives a plain counter of ones. Another control input places the two ramps either inside the programmed period or around it.

The comparator stream carries no valid and no ready signal: the modulator cannot stall, so every clock of a measurement carries a bit. The result interface is a one-clock valid strobe with no ready and no back-pressure. The result word holds its value until the next strobe, so a consumer may read it at any time between strobes.

Top module: `twin_accum_top`

## Requirements
- R1: After reset, `done_o` is 0, `result_o` is 0 and the block is idle.
- R2: A high `start_i` seen at a clock edge while idle launches a measurement. The measurement accepts `bit_i` on the next T edges. In inside mode (`ramps_outside_i`=0), T is the larger of `period_i` and 64. In around mode (`ramps_outside_i`=1), T is `period_i`+64. `done_o` is high for exactly one clock, asserted at the edge that takes the last sample.
- R3: The ramp uses the increment table inc(k), with k from 0 to 31: 0 for k in 0..1, 1 for k in 2..4, 2 for k in 5..8, 3 for k in 9..22, 2 for k in 23..26, 1 for k in 27..29, 0 for k in 30..31. With the window on, sample k (k < 32) has weight W(k), the sum of inc(0) through inc(k). W(31) is 64.
- R4: With the window on, sample T-1-k (k < 32) has weight W(k). The window register is back at 0 after the last sample.
- R5: With the window on, every sample from index 32 to T-33 has weight 64.
- R6: With `window_off_i`=1, every sample has weight 64, so the result is twice the number of ones.
- R7: With S the weighted sum, `result_o` equals floor((S+16)/32). The division rounds to nearest and does not truncate.
- R8: A `start_i` pulse during a measurement is ignored. The running measurement keeps its length and result.
- R9: `period_i`, `ramps_outside_i` and `window_off_i` are captured when the measurement launches. Changes to them during a measurement have no effect on it.
- R10: `result_o` changes only at the edge that raises `done_o`, and it holds between measurements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch strobe, acted on only when idle |
| period_i | input | PER_W | Programmed period N |
| ramps_outside_i | input | 1 | 1: ramps are added around N; 0: ramps fall inside N |
| window_off_i | input | 1 | 1: flat weight of 64 on every sample |
| bit_i | input | 1 | Comparator bit, one per clock |
| result_o | output | PER_W+3 | Rounded, scaled conversion result |
| done_o | output | 1 | One-clock strobe marking a new result |

## Verification
The bench aims at the ramp seams. A bit placed at ramp positions whose weights sum to exactly 16 must round up to 1; a design that truncates returns 0. An all-ones stream over a 64-sample measurement has no flat body, so an off-by-one in the increment lookup or in the down-ramp reversal shifts the sum away from the bench's value. Periods below 64 in inside mode, and a period of 0 in around mode, expose errors in the length arithmetic as a done strobe that comes early or late. Start pulses and control changes injected mid-measurement catch a design that restarts, or that samples its settings live, because the length or the sum then changes.

// File: rtl/twin_pkg.sv
package twin_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_UP   = 2'd1,
    PH_MID  = 2'd2,
    PH_DOWN = 2'd3
  } phase_t;

  localparam int unsigned POS_W   = 5;
  localparam int unsigned WIN_W   = 7;
  localparam int unsigned FULL_WT = 64;
  localparam int unsigned SCALE_SH = 5;

  // Step added to the window at ramp position k; the steps sum to 64.
  function automatic logic [1:0] ramp_inc(input logic [POS_W-1:0] k);
    logic [1:0] r;
    if (k < 5'd2)       r = 2'd0;
    else if (k < 5'd5)  r = 2'd1;
    else if (k < 5'd9)  r = 2'd2;
    else if (k < 5'd23) r = 2'd3;
    else if (k < 5'd27) r = 2'd2;
    else if (k < 5'd30) r = 2'd1;
    else                r = 2'd0;
    return r;
  endfunction

endpackage

// File: rtl/twin_seq.sv
module twin_seq
  import twin_pkg::*;
#(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             outside_i,
  output phase_t           phase_o,
  output logic [POS_W-1:0] pos_o,
  output logic             launch_o,
  output logic             last_o
);

  localparam logic [PER_W-1:0] RAMP_PAIR = PER_W'(2 * (1 << POS_W));
  localparam logic [POS_W-1:0] POS_END   = '1;

  phase_t           phase_q;
  logic [POS_W-1:0] pos_q;
  logic [PER_W-1:0] mid_q;
  logic [PER_W-1:0] mid_len;

  always_comb begin
    if (outside_i)                  mid_len = period_i;
    else if (period_i < RAMP_PAIR)  mid_len = '0;
    else                            mid_len = period_i - RAMP_PAIR;
  end

  assign launch_o = (phase_q == PH_IDLE) && start_i;
  assign last_o   = (phase_q == PH_DOWN) && (pos_q == POS_END);
  assign phase_o  = phase_q;
  assign pos_o    = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pos_q   <= '0;
      mid_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_UP;
            pos_q   <= '0;
            mid_q   <= mid_len;
          end
        end
        PH_UP: begin
          pos_q <= pos_q + 5'd1;
          if (pos_q == POS_END)
            phase_q <= (mid_q == '0) ? PH_DOWN : PH_MID;
        end
        PH_MID: begin
          mid_q <= mid_q - 1'b1;
          if (mid_q == PER_W'(1)) phase_q <= PH_DOWN;
        end
        PH_DOWN: begin
          pos_q <= pos_q + 5'd1;
          if (pos_q == POS_END) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && !last_o) |=> (phase_q != PH_IDLE));

  // R8
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_UP && pos_q != POS_END) |=>
      (phase_q == PH_UP && pos_q == $past(pos_q) + 5'd1));

  // R2
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/twin_weight.sv
module twin_weight
  import twin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  phase_t           phase_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             launch_i,
  input  logic             off_i,
  output logic [WIN_W-1:0] weight_o
);

  localparam logic [WIN_W-1:0] FULL = WIN_W'(FULL_WT);

  logic [WIN_W-1:0] win_q;
  logic             off_q;
  logic [WIN_W-1:0] up_val;
  logic [1:0]       up_step;
  logic [1:0]       dn_step;

  assign up_step = ramp_inc(pos_i);
  assign dn_step = ramp_inc(~pos_i);
  assign up_val  = win_q + {5'd0, up_step};

  always_comb begin
    if (off_q) weight_o = FULL;
    else begin
      unique case (phase_i)
        PH_UP:   weight_o = up_val;
        PH_MID:  weight_o = FULL;
        PH_DOWN: weight_o = win_q;
        default: weight_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= '0;
      off_q <= 1'b0;
    end else if (launch_i) begin
      win_q <= '0;
      off_q <= off_i;
    end else if (phase_i == PH_UP) begin
      win_q <= up_val;
    end else if (phase_i == PH_DOWN) begin
      win_q <= win_q - {5'd0, dn_step};
    end
  end

  // R3
  win_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= FULL);

  // R3
  ramp_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_UP && pos_i == 5'd31) |=> (win_q == FULL));

  // R5
  mid_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_MID) |-> (win_q == FULL));

  // R4
  ramp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_DOWN && pos_i == 5'd31) |=> (win_q == '0));

endmodule

// File: rtl/twin_acc.sv
module twin_acc
  import twin_pkg::*;
#(
  parameter int unsigned PER_W = 16,
  localparam int unsigned ACC_W = PER_W + 8,
  localparam int unsigned RES_W = PER_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic             sample_i,
  input  logic             last_i,
  input  logic             bit_i,
  input  logic [WIN_W-1:0] weight_i,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);

  localparam logic [ACC_W-1:0] HALF_LSB = ACC_W'(1 << (SCALE_SH - 1));

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nx;
  logic [ACC_W-1:0] rounded;

  assign acc_nx  = acc_q + (bit_i ? ACC_W'(weight_i) : '0);
  assign rounded = (acc_nx + HALF_LSB) >> SCALE_SH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (launch_i) begin
        acc_q <= '0;
      end else if (sample_i) begin
        acc_q <= acc_nx;
        if (last_i) begin
          result_o <= RES_W'(rounded);
          done_o   <= 1'b1;
        end
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> done_o);

endmodule

// File: rtl/twin_accum_top.sv
module twin_accum_top
  import twin_pkg::*;
#(
  parameter int unsigned PER_W = 16,
  localparam int unsigned RES_W = PER_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             ramps_outside_i,
  input  logic             window_off_i,
  input  logic             bit_i,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);

  phase_t           phase;
  logic [POS_W-1:0] pos;
  logic             launch;
  logic             last;
  logic [WIN_W-1:0] weight;

  twin_seq #(.PER_W(PER_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .period_i (period_i),
    .outside_i(ramps_outside_i),
    .phase_o  (phase),
    .pos_o    (pos),
    .launch_o (launch),
    .last_o   (last)
  );

  twin_weight u_weight (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (phase),
    .pos_i   (pos),
    .launch_i(launch),
    .off_i   (window_off_i),
    .weight_o(weight)
  );

  twin_acc #(.PER_W(PER_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch_i(launch),
    .sample_i(phase != PH_IDLE),
    .last_i  (last),
    .bit_i   (bit_i),
    .weight_i(weight),
    .result_o(result_o),
    .done_o  (done_o)
  );

endmodule

// File: tb/twin_accum_top_tb.sv
`timescale 1ns/1ps
module twin_accum_top_tb;

  localparam int PER_W = 16;
  localparam int RES_W = PER_W + 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [PER_W-1:0] period_i = '0;
  logic             ramps_outside_i = 1'b0;
  logic             window_off_i = 1'b0;
  logic             bit_i = 1'b0;
  logic [RES_W-1:0] result_o;
  logic             done_o;

  int checks = 0;
  int errors = 0;
  bit b [1024];

  always #4 clk = ~clk;

  twin_accum_top #(.PER_W(PER_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .period_i(period_i),
    .ramps_outside_i(ramps_outside_i), .window_off_i(window_off_i),
    .bit_i(bit_i), .result_o(result_o), .done_o(done_o)
  );

  function automatic int step_of(int k);
    if (k < 2) return 0;
    if (k < 5) return 1;
    if (k < 9) return 2;
    if (k < 23) return 3;
    if (k < 27) return 2;
    if (k < 30) return 1;
    return 0;
  endfunction

  function automatic int ramp_w(int k);
    int s = 0;
    for (int i = 0; i <= k; i++) s += step_of(i);
    return s;
  endfunction

  function automatic int meas_len(int n, bit outside);
    if (outside) return n + 64;
    return (n < 64) ? 64 : n;
  endfunction

  function automatic int expect_res(int t, bit off);
    int s = 0;
    for (int i = 0; i < t; i++) begin
      int w;
      if (off) w = 64;
      else if (i < 32) w = ramp_w(i);
      else if (i >= t - 32) w = ramp_w(t - 1 - i);
      else w = 64;
      if (b[i]) s += w;
    end
    return (s + 16) / 32;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 random, 1 ones, 2 zeros, 3 preset in b; intrude>0 injects a start
  // pulse and changed settings at that sample index (R8, R9)
  task automatic run(int n, bit outside, bit off, int kind, int intrude, string req);
    int t = meas_len(n, outside);
    int exp;
    bit early = 0;
    for (int i = 0; i < t; i++) begin
      if (kind == 0) b[i] = 1'($urandom_range(0, 1));
      else if (kind == 1) b[i] = 1'b1;
      else if (kind == 2) b[i] = 1'b0;
    end
    exp = expect_res(t, off);
    @(negedge clk);
    start_i = 1'b1; period_i = PER_W'(n); ramps_outside_i = outside; window_off_i = off;
    for (int i = 0; i < t; i++) begin
      @(negedge clk);
      start_i = (intrude > 0 && i == intrude);
      if (intrude > 0 && i >= 1) begin
        period_i = PER_W'(n + 500); ramps_outside_i = ~outside; window_off_i = ~off;
      end
      bit_i = b[i];
      if (done_o) early = 1;
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(!early, {req, " R2 no early done"}, early, 0);
    chk(done_o == 1'b1, {req, " R2 done at last sample"}, done_o, 1);
    chk(result_o == RES_W'(exp), {req, " result"}, result_o, exp);
    @(negedge clk);
    chk(done_o == 1'b0 && result_o == RES_W'(exp), {req, " R10 hold, R2 single pulse"},
        result_o, exp);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL R2 watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b0 && result_o == '0, "R1 reset state", result_o, 0);

    run(64, 1'b0, 1'b0, 1, 0, "R3 R4 all ones, 64 samples");
    run(100, 1'b0, 1'b0, 1, 0, "R5 all ones inside mode");
    run(10, 1'b0, 1'b0, 1, 0, "R2 short period clamps to 64");
    run(0, 1'b1, 1'b0, 1, 0, "R2 around mode period 0");
    run(37, 1'b1, 1'b1, 1, 0, "R6 window off all ones");
    run(80, 1'b0, 1'b0, 2, 0, "R5 all zeros");

    for (int i = 0; i < 128; i++) b[i] = 1'b0;
    b[3] = 1'b1; b[9] = 1'b1;
    run(128, 1'b0, 1'b0, 3, 0, "R7 sum 16 rounds up");
    for (int i = 0; i < 128; i++) b[i] = 1'b0;
    b[127 - 3] = 1'b1; b[127 - 9] = 1'b1;
    run(128, 1'b0, 1'b0, 3, 0, "R4 R7 down-ramp sum 16");

    run(90, 1'b0, 1'b0, 0, 5, "R8 R9 intrusion inside");
    run(20, 1'b1, 1'b1, 0, 40, "R8 R9 intrusion around");

    for (int r = 0; r < 24; r++)
      run($urandom_range(0, 400), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          0, 0, "R3 R4 R5 R6 R7 random");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule